// File: doc/BRIEF.md
# Word-to-Byte Bus Lane Bridge

This block sits between a 32-bit Wishbone slave port and a bank of 8-bit registers, such as the register set of a 16550-style serial controller. Each bus access carries a word address and a one-hot byte select. The bridge combines them into a single byte address for the register bank. How a select lane turns into the low address bits depends on a byte-order parameter that is fixed when the design is built. The default is big-endian, and little-endian must be chosen explicitly.

For a write, the bridge picks the byte from the selected lane of the 32-bit write data. It hands that byte to the register bank together with a write pulse that lasts one cycle. For a read, the register bank answers combinationally from the byte address. The bridge registers that byte and returns it on the same lane it was requested on, with zeros on the other three lanes. Every request is acknowledged for one cycle, one cycle after it arrives. A select that is not one-hot still gets an acknowledge, but it writes nothing and returns all zeros.

Top module: `wbByteBridge`

## Requirements
- R1: With BIG_ENDIAN=1, a request whose select has only bit i set drives regAddr = {wbAdr[7:2], 3-i}. So select 4'b0001 reaches byte 3 and select 4'b1000 reaches byte 0.
- R2: With BIG_ENDIAN=0, a request whose select has only bit i set drives regAddr = {wbAdr[7:2], i}.
- R3: regWrEn is high in exactly the cycles where wbCyc, wbStb and wbWe are high, wbAck is low and the select is one-hot. In those cycles regWrData equals wbDatIn[8i+7:8i], where i is the selected lane.
- R4: In a read request cycle the bridge captures regRdData. From the next cycle on, wbDatOut carries that byte on bits 8i+7:8i of the selected lane and zero on every other lane. Addresses the bank does not map return 8'h00.
- R5: wbAck rises in the cycle after a request (wbCyc and wbStb high while wbAck is low) and stays high for exactly one cycle. wbAck is low in the cycle after wbCyc or wbStb was low.
- R6: A request whose select has zero bits or two or more bits set produces no write pulse. It is still acknowledged, and if it is a read it returns wbDatOut = 0.
- R7: While rstN is low, wbAck and wbDatOut are 0.
- R8: wbDatOut changes only in the cycle after a read request. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wbCyc | input | 1 | Bus cycle valid |
| wbStb | input | 1 | Transfer strobe |
| wbWe | input | 1 | 1 = write, 0 = read |
| wbAdr | input | ADDR_W (8) | Byte address of the word; bits 1:0 ignored |
| wbSel | input | BUS_BYTES (4) | Byte-lane select, one-hot for a valid access |
| wbDatIn | input | 8*BUS_BYTES (32) | Write data |
| wbDatOut | output | 8*BUS_BYTES (32) | Registered read data, steered to the selected lane |
| wbAck | output | 1 | One-cycle acknowledge |
| regAddr | output | ADDR_W (8) | Internal byte address |
| regWrData | output | 8 | Byte to write into the register bank |
| regWrEn | output | 1 | One-cycle write pulse |
| regRdData | input | 8 | Combinational read byte from the register bank |

## Verification
An acknowledge and the next request can occur in the same cycle. This happens when the master keeps wbStb asserted across the acknowledge. The bench provokes it with back-to-back reads and writes that hold wbCyc and wbStb high for several cycles. A behavioural model run alongside the design predicts, for every cycle, whether a new request is taken: it must be ignored while wbAck is high and taken again in the cycle after. The model checks that no second write pulse and no fresh read capture appear in the acknowledge cycle. It also checks that the data returned afterwards belongs to the correct lane and the correct byte order.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

  // Strobes handed from the control half to the datapath half.
  // The lane index is sized for the widest bus supported (up to 16 lanes).
  localparam int MAX_LANE_W = 4;

  typedef struct packed {
    logic                  req;    // new transfer accepted this cycle
    logic                  rd;     // accepted transfer is a read
    logic                  wr;     // accepted transfer is a valid write
    logic                  valid;  // select is one-hot
    logic [MAX_LANE_W-1:0] lane;   // position of the selected lane
  } wbbStrobes_t;

endpackage

// File: rtl/wbbControl.sv
module wbbControl
  import wbb_pkg::*;
#(
  parameter int BUS_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wbCyc,
  input  logic                 wbStb,
  input  logic                 wbWe,
  input  logic [BUS_BYTES-1:0] wbSel,
  output wbbStrobes_t          strobes,
  output logic                 wbAck
);

  localparam int LANE_W  = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;
  localparam int COUNT_W = $clog2(BUS_BYTES + 1);

  logic               ackQ;
  logic               reqNow;
  logic [COUNT_W-1:0] selCount;
  logic [LANE_W-1:0]  laneIdx;
  logic               selOneHot;

  // Count the asserted select bits and find the highest one.
  always_comb begin
    selCount = '0;
    laneIdx  = '0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (wbSel[i]) begin
        selCount = selCount + COUNT_W'(1);
        laneIdx  = LANE_W'(i);
      end
    end
  end

  assign selOneHot = (selCount == COUNT_W'(1));

  // A request is taken only while no acknowledge is outstanding.
  assign reqNow = wbCyc & wbStb & ~ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= reqNow;
  end

  always_comb begin
    strobes       = '0;
    strobes.req   = reqNow;
    strobes.rd    = reqNow & ~wbWe;
    strobes.wr    = reqNow & wbWe & selOneHot;
    strobes.valid = selOneHot;
    strobes.lane  = MAX_LANE_W'(laneIdx);
  end

  assign wbAck = ackQ;

endmodule

// File: rtl/wbbDatapath.sv
module wbbDatapath
  import wbb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BUS_BYTES  = 4,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wbbStrobes_t            strobes,
  input  logic [ADDR_W-1:0]      wbAdr,
  input  logic [8*BUS_BYTES-1:0] wbDatIn,
  input  logic [7:0]             regRdData,
  output logic [ADDR_W-1:0]      regAddr,
  output logic [7:0]             regWrData,
  output logic                   regWrEn,
  output logic [8*BUS_BYTES-1:0] wbDatOut
);

  localparam int LANE_W = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;
  localparam int DATA_W = 8 * BUS_BYTES;

  logic [LANE_W-1:0] lane;
  logic [LANE_W-1:0] byteIdx;
  logic [DATA_W-1:0] steered;
  logic [DATA_W-1:0] datQ;

  assign lane = strobes.lane[LANE_W-1:0];

  // The byte order picks how a lane maps to the low address bits.
  generate
    if (BIG_ENDIAN) begin : g_big
      assign byteIdx = LANE_W'(BUS_BYTES - 1) - lane;
    end else begin : g_little
      assign byteIdx = lane;
    end
  endgenerate

  assign regAddr   = {wbAdr[ADDR_W-1:LANE_W], byteIdx};
  assign regWrData = wbDatIn[8*lane +: 8];
  assign regWrEn   = strobes.wr;

  // Put the returned byte on its own lane and zero on all other lanes.
  generate
    for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
      assign steered[8*g +: 8] =
        (strobes.valid && (lane == LANE_W'(g))) ? regRdData : 8'h00;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          datQ <= '0;
    else if (strobes.rd) datQ <= steered;
  end

  assign wbDatOut = datQ;

endmodule

// File: rtl/wbByteBridge.sv
module wbByteBridge
  import wbb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BUS_BYTES  = 4,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wbCyc,
  input  logic                   wbStb,
  input  logic                   wbWe,
  input  logic [ADDR_W-1:0]      wbAdr,
  input  logic [BUS_BYTES-1:0]   wbSel,
  input  logic [8*BUS_BYTES-1:0] wbDatIn,
  output logic [8*BUS_BYTES-1:0] wbDatOut,
  output logic                   wbAck,
  output logic [ADDR_W-1:0]      regAddr,
  output logic [7:0]             regWrData,
  output logic                   regWrEn,
  input  logic [7:0]             regRdData
);

  wbbStrobes_t strobes;

  wbbControl #(.BUS_BYTES(BUS_BYTES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wbCyc   (wbCyc),
    .wbStb   (wbStb),
    .wbWe    (wbWe),
    .wbSel   (wbSel),
    .strobes (strobes),
    .wbAck   (wbAck)
  );

  wbbDatapath #(
    .ADDR_W     (ADDR_W),
    .BUS_BYTES  (BUS_BYTES),
    .BIG_ENDIAN (BIG_ENDIAN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wbAdr     (wbAdr),
    .wbDatIn   (wbDatIn),
    .regRdData (regRdData),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .wbDatOut  (wbDatOut)
  );

endmodule

// File: rtl/wbbChecker.sv
module wbbChecker #(
  parameter int ADDR_W     = 8,
  parameter int BUS_BYTES  = 4,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wbCyc,
  input logic                   wbStb,
  input logic                   wbWe,
  input logic [ADDR_W-1:0]      wbAdr,
  input logic [BUS_BYTES-1:0]   wbSel,
  input logic [8*BUS_BYTES-1:0] wbDatIn,
  input logic [8*BUS_BYTES-1:0] wbDatOut,
  input logic                   wbAck,
  input logic [ADDR_W-1:0]      regAddr,
  input logic [7:0]             regWrData,
  input logic                   regWrEn,
  input logic [7:0]             regRdData
);

  localparam int LANE_W = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;

  logic                 pastOk;
  logic [BUS_BYTES-1:0] lanesUsed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_used
    assign lanesUsed[g] = |wbDatOut[8*g +: 8];
  end

  // R5
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbStb && !wbAck) |=> wbAck);

  // R5
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |=> !wbAck);

  // R5
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wbCyc && wbStb) |=> !wbAck);

  // R3
  wr_only_on_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (wbCyc && wbStb && wbWe && !wbAck));

  // R6
  bad_sel_nowr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(wbSel) != 1) |-> !regWrEn);

  // R4
  one_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lanesUsed));

  // R8
  dat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(wbCyc && wbStb && !wbAck && !wbWe)) |-> $stable(wbDatOut));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!wbAck && (wbDatOut == '0)));

  // R1 R2
  addr_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbStb) |-> (regAddr[ADDR_W-1:LANE_W] == wbAdr[ADDR_W-1:LANE_W]));

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_map
    // R1 R2
    lane_map_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wbCyc && wbStb && (wbSel == BUS_BYTES'(1 << i))) |->
        (regAddr[LANE_W-1:0] ==
         (BIG_ENDIAN ? LANE_W'(BUS_BYTES - 1 - i) : LANE_W'(i))));
  end

endmodule

bind wbByteBridge wbbChecker #(
  .ADDR_W     (ADDR_W),
  .BUS_BYTES  (BUS_BYTES),
  .BIG_ENDIAN (BIG_ENDIAN)
) u_chk (.*);

// File: tb/sim_wbByteBridge.sv
`timescale 1ns/1ps
module sim_wbByteBridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0;
  logic [7:0]  wbAdr = '0;
  logic [3:0]  wbSel = '0;
  logic [31:0] wbDatIn = '0;

  logic [31:0] datOut [2];
  logic        ack    [2];
  logic [7:0]  rAddr  [2];
  logic [7:0]  wrData [2];
  logic        wrEn   [2];
  logic [7:0]  rdData [2];

  // Bench register banks (8 mapped bytes each) and model state
  logic [7:0]  memM [2][8];
  bit          mAck [2];
  logic [31:0] mDat [2];

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  assign rdData[0] = (rAddr[0] < 8'd8) ? memM[0][rAddr[0][2:0]] : 8'h00;
  assign rdData[1] = (rAddr[1] < 8'd8) ? memM[1][rAddr[1][2:0]] : 8'h00;

  wbByteBridge #(.ADDR_W(8), .BUS_BYTES(4), .BIG_ENDIAN(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbSel(wbSel), .wbDatIn(wbDatIn), .wbDatOut(datOut[0]),
    .wbAck(ack[0]), .regAddr(rAddr[0]), .regWrData(wrData[0]),
    .regWrEn(wrEn[0]), .regRdData(rdData[0]));

  wbByteBridge #(.ADDR_W(8), .BUS_BYTES(4), .BIG_ENDIAN(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbSel(wbSel), .wbDatIn(wbDatIn), .wbDatOut(datOut[1]),
    .wbAck(ack[1]), .regAddr(rAddr[1]), .regWrData(wrData[1]),
    .regWrEn(wrEn[1]), .regRdData(rdData[1]));

  task automatic check(input bit ok, input string tag, input int k,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (inst %0d) actual=%h expected=%h at %0t", tag, k, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // One bus cycle: drive at the falling edge, compare, then advance the model.
  task automatic step(input bit c, input bit s, input bit w, input logic [7:0] a,
                      input logic [3:0] sel, input logic [31:0] d);
    int     ones, lane;
    bit     req, valid, expWr, big;
    logic [7:0] expAddr, rd;
    @(negedge clk);
    wbCyc = c; wbStb = s; wbWe = w; wbAdr = a; wbSel = sel; wbDatIn = d;
    #1;
    ones = 0; lane = 0;
    for (int i = 0; i < 4; i++) if (sel[i]) begin ones++; lane = i; end
    valid = (ones == 1);
    for (int k = 0; k < 2; k++) begin
      big     = (k == 0);
      req     = c && s && !mAck[k];
      expWr   = req && w && valid;
      expAddr = {a[7:2], big ? 2'(3 - lane) : 2'(lane)};
      check(ack[k] == mAck[k], "R5 ack", k, 32'(ack[k]), 32'(mAck[k]));
      check(datOut[k] == mDat[k], "R4/R8 read data", k, datOut[k], mDat[k]);
      if (valid)
        check(wrEn[k] == expWr, "R3 write pulse", k, 32'(wrEn[k]), 32'(expWr));
      else
        check(wrEn[k] == 1'b0, "R6 write pulse on bad select", k, 32'(wrEn[k]), 32'd0);
      if (req && valid)
        check(rAddr[k] == expAddr, big ? "R1 byte address" : "R2 byte address",
              k, 32'(rAddr[k]), 32'(expAddr));
      if (expWr)
        check(wrData[k] == d[8*lane +: 8], "R3 write byte", k,
              32'(wrData[k]), 32'(d[8*lane +: 8]));
      // advance model to the next rising edge
      if (req && !w) begin
        rd = (expAddr < 8'd8) ? memM[k][expAddr[2:0]] : 8'h00;
        mDat[k] = valid ? (32'(rd) << (8 * lane)) : 32'h0;
      end
      if (expWr && expAddr < 8'd8) memM[k][expAddr[2:0]] = d[8*lane +: 8];
      mAck[k] = req;
    end
  endtask

  task automatic xfer(input bit w, input logic [7:0] a, input logic [3:0] sel,
                      input logic [31:0] d);
    step(1, 1, w, a, sel, d);
    step(1, 0, 0, a, sel, d);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : stim
    logic [31:0] lfsr = 32'hACE1_1234;
    for (int k = 0; k < 2; k++) begin
      mAck[k] = 0; mDat[k] = '0;
      for (int j = 0; j < 8; j++) memM[k][j] = 8'h00;
    end
    repeat (3) @(negedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      check(ack[k] == 1'b0, "R7 reset ack", k, 32'(ack[k]), 32'd0);
      check(datOut[k] == 32'h0, "R7 reset data", k, datOut[k], 32'h0);
    end
    @(negedge clk); rstN = 1'b1;

    // R3 writes on each lane of word 0 and word 4
    for (int i = 0; i < 4; i++) xfer(1, 8'h00, 4'(1 << i), 32'h44332211 + 32'(i) * 32'h01010101);
    for (int i = 0; i < 4; i++) xfer(1, 8'h05, 4'(1 << i), 32'hA0B0C0D0 ^ 32'(i * 17));
    // R1 R2 R4 reads back on each lane
    for (int i = 0; i < 4; i++) xfer(0, 8'h00, 4'(1 << i), 32'h0);
    for (int i = 0; i < 4; i++) xfer(0, 8'h04, 4'(1 << i), 32'h0);
    // R4 unmapped word returns zero
    xfer(0, 8'h08, 4'b0001, 32'h0);
    xfer(0, 8'hFC, 4'b1000, 32'h0);
    // R8 write and idle leave read data unchanged
    xfer(0, 8'h00, 4'b0010, 32'h0);
    xfer(1, 8'h10, 4'b0100, 32'hFFFFFFFF);
    step(0, 1, 0, 8'h00, 4'b0001, 0);
    step(1, 0, 0, 8'h00, 4'b0001, 0);
    // R6 bad selects
    xfer(1, 8'h00, 4'b0000, 32'h5A5A5A5A);
    xfer(1, 8'h00, 4'b0011, 32'h5A5A5A5A);
    xfer(0, 8'h00, 4'b1111, 32'h0);
    xfer(0, 8'h04, 4'b0000, 32'h0);
    xfer(0, 8'h00, 4'b0001, 32'h0);
    // R5 strobe held across the acknowledge
    for (int i = 0; i < 6; i++) step(1, 1, 1, 8'h04, 4'(1 << (i % 4)), 32'h13579BDF + 32'(i));
    for (int i = 0; i < 6; i++) step(1, 1, 0, 8'h04, 4'(1 << (i % 4)), 0);
    step(0, 0, 0, 0, 0, 0);
    // mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      logic [3:0] sel;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sel = (lfsr[10:8] == 3'd0) ? lfsr[15:12] : 4'(1 << lfsr[5:4]);
      step(lfsr[20] | lfsr[23], lfsr[17] | lfsr[19], lfsr[2],
           {lfsr[28], 2'b00, lfsr[27:25], lfsr[7:6]}, sel, lfsr ^ 32'h9E3779B9);
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    summary();
  end

endmodule